// File: doc/BRIEF.md
# Random Word Buffer with Software Handshake

This block is the register-side buffer of a hardware random number source. A free-running entropy source presents one bit at a time with a valid strobe. The block shifts those bits into a 128-bit staging pool. When the pool has been completely refreshed and enough clock cycles have passed, it copies the pool into four 32-bit data words and sets a ready flag. Software reads the four words and then writes a one to the ready bit. That write clears the flag and starts the next refill.

The length of a refill is bounded by two programmed cycle counts. The lower count keeps a new result from appearing too soon after the acknowledge. The upper count caps the lower one when it is programmed smaller. The data words are never published before 128 fresh bits have arrived.

Health-test alarms from outside logic arrive as single-cycle pulses. They are held in sticky status bits that software clears by writing a one. Each alarm has its own interrupt mask enable, and a single interrupt line is the OR of the enabled alarms. A global enable bit in the control register starts and stops collection.

Top module: `rng_word_buffer`

## Requirements
- R1: After a synchronous reset, every register reads zero, the ready flag is clear and `irq` is low.
- R2: The control register at offset 0x14 reads back every bit written to it. Only these fields act: bit 10 (enable), bit 8 (test mode) and bits 7:1 (interrupt masks). The configuration register at offset 0x18 also reads back every bit written. Its bits 31:16 are the upper refill count and bits 7:0 are the lower refill count.
- R3: With enable set, 128 accepted bits (`ent_valid` high) fill the pool. The bits are published to the data words at 0x00, 0x04, 0x08 and 0x0C, and the ready flag (status bit 0 at 0x10) is set. The word at 0x0C holds the first 32 bits accepted, first bit at bit 31. The word at 0x00 holds the last 32 bits, last bit at bit 0.
- R4: Count clock edges from the edge that applies the acknowledge (or the enable). Ready is set on the edge after the later of two points: the edge that accepts the 128th bit, and the edge on which that count reaches the refill threshold.
- R5: The refill threshold is the smaller of the lower and upper configured counts.
- R6: The data words keep their previous values throughout a refill. Bits offered while ready is set are ignored and do not change the words.
- R7: Writing a one to status bit 0 while ready is set clears ready and starts a new refill from zero bits. Writing a zero there has no effect.
- R8: Clearing the enable bit clears ready on the following edge and discards a partly filled pool. After re-enable, a full 128 new bits are needed.
- R9: A pulse on `alarm_pulse[j]` (j = 1..7) sets status bit j, which stays set until a one is written to it. A pulse in the same cycle as the clearing write leaves the bit set.
- R10: `irq` is high exactly when some status bit j in 1..7 is set and control bit j is set.
- R11: Writes to the data word offsets and to unmapped offsets are ignored, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ent_bit | input | 1 | Entropy source bit |
| ent_valid | input | 1 | Entropy bit is valid this cycle |
| alarm_pulse | input | 7 | Health-test failure pulses, bits 7:1 map to status bits 7:1 |
| irq | output | 1 | Masked OR of the alarm status bits |

## Verification
The bench counts clock edges from the acknowledge to the cycle in which ready appears. It does this with the threshold below 128, above 128, and with the upper count capping the lower one. An off-by-one in the counters, or a threshold taken from the wrong field, shows up as a wrong edge count. The published words are compared bit for bit against the accepted stream, so a reversed word or bit order fails at once. The bench also feeds bits while ready is set, disables the block in the middle of a refill and then tops up the pool, and raises an alarm pulse together with its clearing write. A design that shifts while ready is set, keeps a stale partial pool, or lets the clear win over a new alarm gives the wrong words, an early ready, or a lost alarm bit.

// File: rtl/rng_buf_pkg.sv
package rng_buf_pkg;

    localparam int ADDR_W    = 8;
    localparam int REG_W     = 32;
    localparam int NUM_WORDS = 4;
    localparam int CNT_W     = 16;
    localparam int LOW_W     = 8;

    localparam logic [ADDR_W-1:0] STAT_OFF = 8'h10;
    localparam logic [ADDR_W-1:0] CTRL_OFF = 8'h14;
    localparam logic [ADDR_W-1:0] CFG_OFF  = 8'h18;

    localparam int EN_BIT    = 10;
    localparam int TEST_BIT  = 8;
    localparam int UPPER_LSB = 16;

    typedef struct packed {
        logic       enable;
        logic [7:1] mask;
    } ctrl_view_t;

    typedef struct packed {
        logic [CNT_W-1:0] upper;
        logic [LOW_W-1:0] lower;
    } refill_cfg_t;

    function automatic ctrl_view_t decode_ctrl(input logic [REG_W-1:0] raw);
        ctrl_view_t v;
        v.enable = raw[EN_BIT];
        v.mask   = raw[7:1];
        return v;
    endfunction

    function automatic refill_cfg_t decode_cfg(input logic [REG_W-1:0] raw);
        refill_cfg_t c;
        c.upper = raw[UPPER_LSB +: CNT_W];
        c.lower = raw[LOW_W-1:0];
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] refill_threshold(input refill_cfg_t c);
        logic [CNT_W-1:0] low_ext;
        low_ext = CNT_W'(c.lower);
        return (low_ext < c.upper) ? low_ext : c.upper;
    endfunction

endpackage

// File: rtl/rng_pool_collector.sv
module rng_pool_collector #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4,
    parameter int CNT_W     = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        en_i,
    input  logic                        ack_i,
    input  logic                        sample_bit_i,
    input  logic                        sample_valid_i,
    input  logic [CNT_W-1:0]            thr_i,
    output logic                        ready_o,
    output logic [WORD_W*NUM_WORDS-1:0] pool_o
);
    localparam int POOL_W    = WORD_W * NUM_WORDS;
    localparam int BIT_CNT_W = $clog2(POOL_W + 1);
    localparam logic [BIT_CNT_W-1:0] FULL_CNT = BIT_CNT_W'(POOL_W);
    localparam logic [CNT_W-1:0]     CYC_SAT  = {CNT_W{1'b1}};

    logic [POOL_W-1:0]    stage_q;
    logic [BIT_CNT_W-1:0] bits_q;
    logic [CNT_W-1:0]     cyc_q;
    logic                 ready_q;
    logic                 collecting;
    logic                 bits_full;
    logic                 cyc_met;
    logic                 restart;
    logic                 load;

    assign collecting = en_i && !ready_q;
    assign bits_full  = (bits_q == FULL_CNT);
    assign cyc_met    = (cyc_q >= thr_i);
    assign restart    = !en_i || (ack_i && ready_q);
    assign load       = collecting && bits_full && cyc_met;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            bits_q  <= '0;
            cyc_q   <= '0;
            ready_q <= 1'b0;
        end else if (restart) begin
            bits_q  <= '0;
            cyc_q   <= '0;
            ready_q <= 1'b0;
        end else if (load) begin
            ready_q <= 1'b1;
        end else if (collecting) begin
            if (cyc_q != CYC_SAT) begin
                cyc_q <= cyc_q + 1'b1;
            end
            if (sample_valid_i) begin
                stage_q <= {stage_q[POOL_W-2:0], sample_bit_i};
                if (!bits_full) begin
                    bits_q <= bits_q + 1'b1;
                end
            end
        end
    end

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (load) begin
                word_q <= stage_q[k*WORD_W +: WORD_W];
            end
        end
        assign pool_o[k*WORD_W +: WORD_W] = word_q;
    end

    assign ready_o = ready_q;

    // R3: ready only appears once the whole pool has been refreshed
    a_r3_full_pool: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_q) |-> ($past(bits_q) == FULL_CNT));

    // R4 / R5: ready never appears before the threshold count
    a_r4_min_cycles: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_q) |-> ($past(cyc_q) >= $past(thr_i)));

    // R6: published words move only when ready rises
    a_r6_words_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(pool_o) |-> $rose(ready_q));

    // R7: acknowledge drops ready on the next edge
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack_i && ready_q) |=> !ready_q);

    // R8: disabled block never shows ready
    a_r8_disable_drops: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !ready_q);

endmodule

// File: rtl/rng_alarm_status.sv
module rng_alarm_status (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:1] pulse_i,
    input  logic [7:1] clr_i,
    input  logic [7:1] mask_i,
    output logic [7:1] flags_o,
    output logic       irq_o
);
    logic [7:1] flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_i) | pulse_i;
        end
    end

    assign flags_o = flags_q;
    assign irq_o   = |(flags_q & mask_i);

    // R9: every pulse leaves its flag set, even against a clearing write
    a_r9_pulse_sets: assert property (@(posedge clk) disable iff (rst)
        (|pulse_i) |=> ((flags_q & $past(pulse_i)) == $past(pulse_i)));

    // R9: a clearing write with no pulse empties the chosen flags
    a_r9_clear_works: assert property (@(posedge clk) disable iff (rst)
        ((|clr_i) && !(|pulse_i)) |=> ((flags_q & $past(clr_i)) == '0));

    // R10: interrupt needs a raised flag
    a_r10_irq_source: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (|flags_q));

endmodule

// File: rtl/rng_word_buffer.sv
module rng_word_buffer
    import rng_buf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              ent_bit,
    input  logic              ent_valid,
    input  logic [7:1]        alarm_pulse,
    output logic              irq
);
    localparam int POOL_W = REG_W * NUM_WORDS;

    logic [REG_W-1:0]  ctrl_q;
    logic [REG_W-1:0]  cfg_q;
    ctrl_view_t        ctrl_v;
    refill_cfg_t       cfg_v;
    logic [CNT_W-1:0]  thr;
    logic              wr_stat;
    logic              ack;
    logic [7:1]        alarm_clr;
    logic              ready;
    logic [7:1]        flags;
    logic [POOL_W-1:0] pool;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cfg_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == CTRL_OFF) ctrl_q <= bus_wdata;
            if (bus_addr == CFG_OFF)  cfg_q  <= bus_wdata;
        end
    end

    assign ctrl_v    = decode_ctrl(ctrl_q);
    assign cfg_v     = decode_cfg(cfg_q);
    assign thr       = refill_threshold(cfg_v);
    assign wr_stat   = bus_wr && (bus_addr == STAT_OFF);
    assign ack       = wr_stat && bus_wdata[0];
    assign alarm_clr = wr_stat ? bus_wdata[7:1] : '0;

    rng_pool_collector #(
        .WORD_W   (REG_W),
        .NUM_WORDS(NUM_WORDS),
        .CNT_W    (CNT_W)
    ) collector_i (
        .clk           (clk),
        .rst           (rst),
        .en_i          (ctrl_v.enable),
        .ack_i         (ack),
        .sample_bit_i  (ent_bit),
        .sample_valid_i(ent_valid),
        .thr_i         (thr),
        .ready_o       (ready),
        .pool_o        (pool)
    );

    rng_alarm_status alarm_i (
        .clk    (clk),
        .rst    (rst),
        .pulse_i(alarm_pulse),
        .clr_i  (alarm_clr),
        .mask_i (ctrl_v.mask),
        .flags_o(flags),
        .irq_o  (irq)
    );

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_WORDS; k++) begin
            if (bus_addr == ADDR_W'(k * 4)) begin
                bus_rdata = pool[k*REG_W +: REG_W];
            end
        end
        if (bus_addr == STAT_OFF) bus_rdata = {{(REG_W-8){1'b0}}, flags, ready};
        if (bus_addr == CTRL_OFF) bus_rdata = ctrl_q;
        if (bus_addr == CFG_OFF)  bus_rdata = cfg_q;
    end

    // R1: outputs quiet in the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!irq && !ready));

    // R10: masked-off alarms never drive the interrupt line
    a_r10_masked_off: assert property (@(posedge clk) disable iff (rst)
        (ctrl_v.mask == '0) |-> !irq);

endmodule

// File: tb/rng_word_buffer_tb_top.sv
`timescale 1ns/1ps
module rng_word_buffer_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        ent_bit;
    logic        ent_valid;
    logic [7:1]  alarm_pulse;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int ticks  = 0;
    logic [127:0] exp_pool;
    logic [31:0]  rd;

    always #10 clk = ~clk;

    rng_word_buffer dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ent_bit(ent_bit),
        .ent_valid(ent_valid), .alarm_pulse(alarm_pulse), .irq(irq)
    );

    // {address, write data, expected read-back}
    localparam logic [95:0] REG_VEC [7] = '{
        {32'h14, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {32'h14, 32'h0000_0000, 32'h0000_0000},
        {32'h14, 32'h0000_012A, 32'h0000_012A},
        {32'h18, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {32'h18, 32'h1234_ABCD, 32'h1234_ABCD},
        {32'h04, 32'hDEAD_BEEF, 32'h0000_0000},
        {32'h1C, 32'h1234_5678, 32'h0000_0000}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
        checks++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, want);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        ticks     = 0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic pattern_bit(input logic [31:0] seed, input int idx);
        return seed[idx % 32] ^ ((idx / 32) % 2 == 1);
    endfunction

    task automatic feed(input logic [31:0] seed, input int start, input int n, input bit model);
        for (int i = 0; i < n; i++) begin
            ent_bit   = pattern_bit(seed, start + i);
            ent_valid = 1'b1;
            if (model) exp_pool = {exp_pool[126:0], ent_bit};
            @(negedge clk);
            ticks++;
        end
        ent_valid = 1'b0;
    endtask

    task automatic wait_ready(input int limit);
        logic [31:0] s;
        for (int i = 0; i < limit; i++) begin
            bus_read(8'h10, s);
            if (s[0]) break;
            @(negedge clk);
            ticks++;
        end
    endtask

    task automatic check_words(input string tag);
        logic [31:0] w;
        for (int k = 0; k < 4; k++) begin
            bus_read(8'(k * 4), w);
            check(tag, w, exp_pool[k*32 +: 32]);
        end
    endtask

    initial begin
        #(20ns * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
        ent_bit = 1'b0; ent_valid = 1'b0; alarm_pulse = '0; exp_pool = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            bus_read(8'(a * 4), rd);
            check("R1 reset register", rd, 32'h0);
        end
        check("R1 irq after reset", {31'b0, irq}, 32'h0);

        // R2 / R11: register vector table
        foreach (REG_VEC[i]) begin
            bus_write(REG_VEC[i][71:64], REG_VEC[i][63:32]);
            bus_read(REG_VEC[i][71:64], rd);
            check("R2/R11 register vector", rd, REG_VEC[i][31:0]);
        end
        check("R2 test mode alone leaves ready clear", {31'b0, rd[0]}, 32'h0);

        // R3 / R4: threshold 0, ready one edge after the 128th bit
        bus_write(8'h18, 32'hFFFF_0000);
        bus_write(8'h14, 32'h0000_0400);
        exp_pool = '0;
        feed(32'hA5C3_0F96, 0, 64, 1);
        bus_read(8'h00, rd);
        check("R6 words hold during refill", rd, 32'h0);
        feed(32'hA5C3_0F96, 64, 64, 1);
        wait_ready(400);
        check("R4 edges to ready, threshold 0", 32'(ticks), 32'd129);
        check_words("R3 published word");

        // R6: bits offered while ready are ignored; R7: writing 0 does nothing
        feed(32'h1357_9BDF, 0, 40, 0);
        check_words("R6 words unchanged while ready");
        bus_write(8'h10, 32'h0);
        bus_read(8'h10, rd);
        check("R7 zero write keeps ready", {31'b0, rd[0]}, 32'h1);

        // R4 with lower count 200 above the bit time; R7 acknowledge
        bus_write(8'h18, 32'hFFFF_00C8);
        bus_write(8'h10, 32'h1);
        bus_read(8'h10, rd);
        check("R7 acknowledge clears ready", {31'b0, rd[0]}, 32'h0);
        exp_pool = '0;
        feed(32'h6E2B_91D4, 0, 128, 1);
        wait_ready(400);
        check("R4 edges to ready, lower count 200", 32'(ticks), 32'd201);
        check_words("R4 published word after long refill");

        // R5: upper count 150 caps lower count 250
        bus_write(8'h18, 32'h0096_00FA);
        bus_write(8'h10, 32'h1);
        exp_pool = '0;
        feed(32'h0F1E_2D3C, 0, 128, 1);
        wait_ready(400);
        check("R5 edges to ready, upper caps lower", 32'(ticks), 32'd151);

        // R8: disable mid-refill discards the partial pool
        bus_write(8'h18, 32'h0);
        bus_write(8'h10, 32'h1);
        feed(32'hFFFF_0000, 0, 100, 0);
        bus_write(8'h14, 32'h0);
        bus_write(8'h14, 32'h0000_0400);
        exp_pool = '0;
        feed(32'h8421_7BDE, 0, 28, 1);
        repeat (3) @(negedge clk);
        bus_read(8'h10, rd);
        check("R8 partial pool discarded", {31'b0, rd[0]}, 32'h0);
        feed(32'h8421_7BDE, 28, 100, 1);
        wait_ready(10);
        bus_read(8'h10, rd);
        check("R8 ready after full refill", {31'b0, rd[0]}, 32'h1);
        check_words("R8 published word after re-enable");
        bus_write(8'h14, 32'h0);
        @(negedge clk);
        bus_read(8'h10, rd);
        check("R8 disable clears ready", {31'b0, rd[0]}, 32'h0);
        bus_read(8'h0C, rd);
        check("R6 words kept after disable", rd, exp_pool[127:96]);

        // R9 / R10: alarms, masks, write-one-to-clear
        bus_write(8'h14, 32'h0000_0004);
        alarm_pulse = 7'b0010000;
        @(negedge clk);
        alarm_pulse = '0;
        bus_read(8'h10, rd);
        check("R9 alarm bit 5 sticky", rd, 32'h20);
        check("R10 masked alarm keeps irq low", {31'b0, irq}, 32'h0);
        alarm_pulse = 7'b0000010;
        @(negedge clk);
        alarm_pulse = '0;
        bus_read(8'h10, rd);
        check("R9 alarm bit 2 sticky", rd, 32'h24);
        check("R10 enabled alarm raises irq", {31'b0, irq}, 32'h1);
        bus_write(8'h10, 32'h04);
        bus_read(8'h10, rd);
        check("R9 clear bit 2 only", rd, 32'h20);
        check("R10 irq drops after clear", {31'b0, irq}, 32'h0);
        bus_addr = 8'h10; bus_wdata = 32'h20; bus_wr = 1'b1;
        alarm_pulse = 7'b0010000;
        @(negedge clk);
        bus_wr = 1'b0; alarm_pulse = '0;
        bus_read(8'h10, rd);
        check("R9 pulse beats clear", rd, 32'h20);
        bus_write(8'h14, 32'h0000_00FE);
        alarm_pulse = 7'b1000000;
        @(negedge clk);
        alarm_pulse = '0;
        #1;
        check("R10 bit 7 mask raises irq", {31'b0, irq}, 32'h1);
        bus_write(8'h10, 32'hFF);
        bus_read(8'h10, rd);
        check("R9 clear all alarms", rd, 32'h0);
        check("R10 irq low with no alarms", {31'b0, irq}, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule